// File: doc/BRIEF.md
# Vectored Interrupt Controller with Event Flags

This block collects interrupt events for a small 4-bit processor and presents one vectored request at a time. Eleven sources feed it. Five are synchronous one-cycle ticks from on-chip logic: two timers, two dividers and a serial port. Six are external active-low pins: two dedicated interrupt pins and a group of four port lines. The external pins are synchronised, and their falling edges are detected. Each event sets a sticky bit in an event flag register.

A source raises a request only under three conditions at once:
- its event flag is set;
- its bit is set in the arm register;
- its bit is set in the mask register.

A global enable must also be on. The request carries a program-memory vector in the window 004H to 023H. When the processor acknowledges, the serviced flags are cleared automatically. The global enable also drops, which locks out further requests until software turns it back on. If a request exists while the processor is in hold mode, the block raises a wake output.

The CPU side is a plain request/acknowledge pair. Software writes the two enable registers, issues enable-all and disable-all commands, and can clear flags by mask.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A one-cycle high pulse on a tick input sets its event flag at the next rising edge. A set flag stays set until it is cleared. The flag bit positions are: 0 pin A, 1 timer 0, 2 timer 1, 3 divider 0, 4 divider 1, 5..8 port lines 0..3, 9 serial, 10 pin B.
- R2: `irq_req` is high only when the global enable is on and at least one source has its flag, arm bit and mask bit all set. A source with either enable bit clear never requests.
- R3: A high-to-low transition on an external pin sets its flag at the third rising edge after the pin changes. A low-to-high transition has no effect, and neither does a steady level.
- R4: An acknowledge while `irq_req` is high clears the flags of the winning vector slot that are armed, masked and pending. It also clears the global enable. All other flags are kept.
- R5: `cmd_ei` or a write to the arm register sets the global enable, and `cmd_di` clears it. Within one cycle the order of precedence is acknowledge first, then disable, then enable.
- R6: `irq_vec` equals 04H plus 4 times the slot number of the winning slot. The slots are: 0 pin A, 1 timer 0, 2 timer 1, 3 divider 0, 4 divider 1, 5 the four port lines together, 6 serial, 7 pin B. `irq_vec` is 0 when no source is armed, masked and pending.
- R7: When several slots qualify at once, the lowest vector address wins.
- R8: `hold_wake` is high exactly when `hold_in` and `irq_req` are both high.
- R9: A software flag clear and a hardware set of the same flag in the same cycle leave that flag set.
- R10: After reset all flags, both enable registers and the global enable are 0, so `irq_req`, `irq_vec` and `hold_wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr0_tick | input | 1 | Timer 0 event pulse |
| tmr1_tick | input | 1 | Timer 1 event pulse |
| div0_tick | input | 1 | Divider 0 event pulse |
| div1_tick | input | 1 | Divider 1 event pulse |
| ser_tick | input | 1 | Serial port event pulse |
| pin_a_n | input | 1 | External interrupt pin A, active low |
| pin_b_n | input | 1 | External interrupt pin B, active low |
| port_n | input | 4 | External port lines, active low |
| hold_in | input | 1 | Processor is in hold mode |
| arm_wr | input | 1 | Write strobe for the arm register |
| arm_data | input | 11 | Arm register write data |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_data | input | 11 | Mask register write data |
| flag_clr | input | 1 | Software flag clear strobe |
| flag_clr_mask | input | 11 | Flags to clear |
| cmd_ei | input | 1 | Enable-all command |
| cmd_di | input | 1 | Disable-all command |
| irq_ack | input | 1 | Processor acknowledge |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector address of the winning slot |
| irq_en | output | 1 | Global enable state |
| hold_wake | output | 1 | Release request for hold mode |
| evt_flags | output | 11 | Event flag register |

## Verification
The hardest case to reach from the ports is the port-line slot, where four flags share one vector. It must be acknowledged while some of those four lines are pending but not armed, and while other slots are also pending. The clear must then remove only the qualified flags of that one slot. Long random runs drive sparse ticks and random pin toggles while rewriting the arm and mask registers. They send a stream of enable commands and acknowledges with random timing, so partial enables inside the shared slot coincide with acknowledges. Directed sequences cover the same-cycle conflicts: set against clear, and enable against disable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 11;
  localparam int NSLOT = 8;
  localparam int NPIN  = 6;

  // Map a source bit to its vector slot; port lines 5..8 share slot 5.
  function automatic int src_slot(input int i);
    if (i < 5)       return i;
    else if (i < 9)  return 5;
    else if (i == 9) return 6;
    else             return 7;
  endfunction

  function automatic logic [NSRC-1:0] slot_mask(input int s);
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++)
      if (src_slot(i) == s) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/irq_fall_det.sv
module irq_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              sync_lvl;

  assign sync_lvl = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_n};
      prev_q  <= sync_lvl;
    end
  end

  assign fall = prev_q & ~sync_lvl;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         sw_clr,
  input  logic [N-1:0] sw_clr_mask,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_nxt, clr_all;
  logic         upd;

  always_comb begin
    clr_all  = ack_clr | (sw_clr ? sw_clr_mask : '0);
    flag_nxt = (flag_q & ~clr_all) | hw_set;
    upd      = (|hw_set) | (|clr_all);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= '0;
    else if (upd) flag_q <= flag_nxt;
  end

  assign flags = flag_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
#(
  parameter int BASE_ADDR = 4,
  parameter int STRIDE    = 4,
  parameter int VEC_W     = 8
) (
  input  logic [NSRC-1:0]  qual,
  output logic             any,
  output logic [VEC_W-1:0] vec,
  output logic [NSRC-1:0]  win_mask
);
  localparam int SLOT_W = $clog2(NSLOT);

  logic [NSLOT-1:0]  pend;
  logic [SLOT_W-1:0] win;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign pend[s] = |(qual & slot_mask(s));
  end

  always_comb begin
    win = '0;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (pend[s]) win = SLOT_W'(s);
  end

  always_comb begin
    win_mask = '0;
    for (int s = 0; s < NSLOT; s++)
      if (win == SLOT_W'(s)) win_mask = slot_mask(s) & qual;
  end

  assign any = |pend;
  assign vec = any ? (VEC_W'(BASE_ADDR) + VEC_W'(STRIDE) * VEC_W'(win)) : '0;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int BASE_ADDR   = 4,
  parameter int SLOT_STRIDE = 4,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr0_tick,
  input  logic             tmr1_tick,
  input  logic             div0_tick,
  input  logic             div1_tick,
  input  logic             ser_tick,
  input  logic             pin_a_n,
  input  logic             pin_b_n,
  input  logic [3:0]       port_n,
  input  logic             hold_in,
  input  logic             arm_wr,
  input  logic [NSRC-1:0]  arm_data,
  input  logic             mask_wr,
  input  logic [NSRC-1:0]  mask_data,
  input  logic             flag_clr,
  input  logic [NSRC-1:0]  flag_clr_mask,
  input  logic             cmd_ei,
  input  logic             cmd_di,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_en,
  output logic             hold_wake,
  output logic [NSRC-1:0]  evt_flags
);
  logic            rst_sync_n;
  logic [NPIN-1:0] pins_n, fall;
  logic [NSRC-1:0] hw_set, qual, win_mask, ack_clr;
  logic [NSRC-1:0] arm_q, mask_q;
  logic            gie_q, gie_nxt, gie_upd;
  logic            any, ack_fire;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign pins_n = {pin_b_n, port_n, pin_a_n};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    irq_fall_det #(.STAGES(SYNC_STAGES)) u_fd (
      .clk(clk), .rst_n(rst_sync_n), .pin_n(pins_n[p]), .fall(fall[p])
    );
  end

  assign hw_set = {fall[5], ser_tick, fall[4:1], div1_tick, div0_tick,
                   tmr1_tick, tmr0_tick, fall[0]};

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .hw_set(hw_set), .sw_clr(flag_clr),
    .sw_clr_mask(flag_clr_mask), .ack_clr(ack_clr), .flags(evt_flags)
  );

  assign qual = evt_flags & arm_q & mask_q;

  irq_prio #(.BASE_ADDR(BASE_ADDR), .STRIDE(SLOT_STRIDE), .VEC_W(VEC_W)) u_prio (
    .qual(qual), .any(any), .vec(irq_vec), .win_mask(win_mask)
  );

  assign irq_req   = gie_q & any;
  assign ack_fire  = irq_ack & irq_req;
  assign ack_clr   = ack_fire ? win_mask : '0;
  assign irq_en    = gie_q;
  assign hold_wake = hold_in & irq_req;

  always_comb begin
    gie_upd = ack_fire | cmd_di | cmd_ei | arm_wr;
    if (ack_fire)             gie_nxt = 1'b0;
    else if (cmd_di)          gie_nxt = 1'b0;
    else                      gie_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      arm_q  <= '0;
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (arm_wr)  arm_q  <= arm_data;
      if (mask_wr) mask_q <= mask_data;
      if (gie_upd) gie_q  <= gie_nxt;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_ack,
  input logic             irq_en,
  input logic             hold_in,
  input logic             hold_wake,
  input logic             cmd_di,
  input logic [NSRC-1:0]  flags,
  input logic [NSRC-1:0]  arm,
  input logic [NSRC-1:0]  mask
);
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_en); // R2
  AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((flags & arm & mask) != '0)); // R2
  AST_ACK_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_en); // R4
  AST_DI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di |=> (!irq_en && !irq_req)); // R5
  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= VEC_W'(8'h04) && irq_vec <= VEC_W'(8'h20) && irq_vec[1:0] == 2'b00)); // R6
  AST_WAKE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wake |-> (hold_in && irq_req)); // R8
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .irq_en(irq_en), .hold_in(hold_in), .hold_wake(hold_wake),
  .cmd_di(cmd_di), .flags(evt_flags), .arm(arm_q), .mask(mask_q)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic tmr0_tick, tmr1_tick, div0_tick, div1_tick, ser_tick;
  logic pin_a_n, pin_b_n;
  logic [3:0] port_n;
  logic hold_in, arm_wr, mask_wr, flag_clr, cmd_ei, cmd_di, irq_ack;
  logic [10:0] arm_data, mask_data, flag_clr_mask;
  logic irq_req, irq_en, hold_wake;
  logic [7:0] irq_vec;
  logic [10:0] evt_flags;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  // bench model state
  logic [10:0] ef, ea, em;
  logic        eg;
  logic [2:0]  hist [6];

  always #2 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tmr0_tick(tmr0_tick), .tmr1_tick(tmr1_tick),
    .div0_tick(div0_tick), .div1_tick(div1_tick), .ser_tick(ser_tick),
    .pin_a_n(pin_a_n), .pin_b_n(pin_b_n), .port_n(port_n), .hold_in(hold_in),
    .arm_wr(arm_wr), .arm_data(arm_data), .mask_wr(mask_wr), .mask_data(mask_data),
    .flag_clr(flag_clr), .flag_clr_mask(flag_clr_mask), .cmd_ei(cmd_ei),
    .cmd_di(cmd_di), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_en(irq_en), .hold_wake(hold_wake), .evt_flags(evt_flags)
  );

  function automatic int slot_of(input int i);
    case (i)
      0, 1, 2, 3, 4: return i;
      9:             return 6;
      10:            return 7;
      default:       return 5;
    endcase
  endfunction

  function automatic int win_slot(input logic [10:0] q);
    int w;
    w = -1;
    for (int i = 0; i < 11; i++)
      if (q[i] && (w < 0 || slot_of(i) < w)) w = slot_of(i);
    return w;
  endfunction

  function automatic logic [7:0] exp_vec(input logic [10:0] q);
    int w;
    w = win_slot(q);
    if (w < 0) return 8'h00;
    return 8'(4 + 4 * w);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    tmr0_tick = 0; tmr1_tick = 0; div0_tick = 0; div1_tick = 0; ser_tick = 0;
    arm_wr = 0; mask_wr = 0; flag_clr = 0; cmd_ei = 0; cmd_di = 0; irq_ack = 0;
  endtask

  // Called at a negedge with inputs already driven; advances one cycle.
  task automatic cyc();
    logic [10:0] q, clr, set, nf;
    logic [5:0]  pins, fall;
    logic        areq, ng;
    int          w;
    #1;
    q    = ef & ea & em;
    areq = eg && (q != 0);
    chk("R1 R4 R9 flags", 32'(evt_flags), 32'(ef));
    chk("R2 req", 32'(irq_req), 32'(areq));
    chk("R6 R7 vec", 32'(irq_vec), 32'(exp_vec(q)));
    chk("R5 en", 32'(irq_en), 32'(eg));
    chk("R8 wake", 32'(hold_wake), 32'(hold_in & areq));
    w   = win_slot(q);
    clr = '0;
    if (irq_ack && areq)
      for (int i = 0; i < 11; i++)
        if (q[i] && slot_of(i) == w) clr[i] = 1'b1;
    if (flag_clr) clr = clr | flag_clr_mask;
    pins = {pin_b_n, port_n, pin_a_n};
    for (int p = 0; p < 6; p++) fall[p] = !hist[p][1] && hist[p][2];
    set = {fall[5], ser_tick, fall[4:1], div1_tick, div0_tick, tmr1_tick, tmr0_tick, fall[0]};
    nf  = (ef & ~clr) | set;
    ng  = eg;
    if (irq_ack && areq) ng = 1'b0;
    else if (cmd_di)     ng = 1'b0;
    else if (cmd_ei || arm_wr) ng = 1'b1;
    @(posedge clk);
    ef = nf;
    eg = ng;
    if (arm_wr)  ea = arm_data;
    if (mask_wr) em = mask_data;
    for (int p = 0; p < 6; p++) hist[p] = {hist[p][1:0], pins[p]};
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed;
    seed = $urandom(32'd24681);
    clear_pulses();
    rst_n = 0; pin_a_n = 1; pin_b_n = 1; port_n = 4'hF; hold_in = 0;
    arm_data = '0; mask_data = '0; flag_clr_mask = '0;
    ef = '0; ea = '0; em = '0; eg = 0;
    for (int p = 0; p < 6; p++) hist[p] = 3'b111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 flags", 32'(evt_flags), 0);
    chk("R10 req", 32'(irq_req), 0);
    chk("R10 vec", 32'(irq_vec), 0);
    chk("R10 en", 32'(irq_en), 0);
    chk("R10 wake", 32'(hold_wake), 0);
    @(negedge clk);

    // arm + mask all; arm write enables globally (R5)
    arm_wr = 1; arm_data = 11'h7FF; mask_wr = 1; mask_data = 11'h7FF;
    cyc();
    chk("R5 arm write enables", 32'(irq_en), 1);

    // R3 falling edge on pin A: flag at third edge
    pin_a_n = 0;
    cyc(); cyc();
    chk("R3 flag not yet", 32'(evt_flags[0]), 0);
    cyc();
    chk("R3 flag set", 32'(evt_flags[0]), 1);
    chk("R6 vec pin A", 32'(irq_vec), 32'h04);

    // R4 acknowledge
    irq_ack = 1;
    cyc();
    chk("R4 flag cleared", 32'(evt_flags[0]), 0);
    chk("R4 lockout", 32'(irq_en), 0);

    // R3 rising edge ignored
    pin_a_n = 1;
    idle(6);
    chk("R3 rising ignored", 32'(evt_flags[0]), 0);

    // R7 priority: timer 1 and serial together, enable off -> no request (R2)
    tmr1_tick = 1; ser_tick = 1;
    cyc();
    chk("R2 no req while disabled", 32'(irq_req), 0);
    cmd_ei = 1;
    cyc();
    chk("R7 lowest vector wins", 32'(irq_vec), 32'h0C);
    irq_ack = 1;
    cyc();
    chk("R4 other flag kept", 32'(evt_flags[9]), 1);
    chk("R4 serviced flag cleared", 32'(evt_flags[2]), 0);
    chk("R6 vec serial", 32'(irq_vec), 32'h1C);

    // R9 set beats clear
    div0_tick = 1; flag_clr = 1; flag_clr_mask = 11'h008;
    cyc();
    chk("R9 set wins", 32'(evt_flags[3]), 1);
    flag_clr = 1; flag_clr_mask = 11'h008;
    cyc();
    chk("R9 clear alone", 32'(evt_flags[3]), 0);

    // R5 disable beats enable
    cmd_ei = 1; cmd_di = 1;
    cyc();
    chk("R5 di over ei", 32'(irq_en), 0);
    arm_wr = 1; arm_data = 11'h7FF; cmd_di = 1;
    cyc();
    chk("R5 di over arm write", 32'(irq_en), 0);

    // R8 hold wake
    hold_in = 1; cmd_ei = 1;
    cyc();
    chk("R8 wake on request", 32'(hold_wake), 1);
    // R2 mask bit off blocks serial
    mask_wr = 1; mask_data = 11'h1FF;
    cyc();
    chk("R2 mask blocks", 32'(irq_req), 0);
    chk("R8 no wake", 32'(hold_wake), 0);
    mask_wr = 1; mask_data = 11'h7FF; hold_in = 0;
    cyc();

    // random phase
    for (int k = 0; k < 4000; k++) begin
      tmr0_tick = ($urandom % 16) == 0;
      tmr1_tick = ($urandom % 16) == 0;
      div0_tick = ($urandom % 16) == 0;
      div1_tick = ($urandom % 16) == 0;
      ser_tick  = ($urandom % 16) == 0;
      if (($urandom % 8) == 0) pin_a_n = ~pin_a_n;
      if (($urandom % 8) == 0) pin_b_n = ~pin_b_n;
      if (($urandom % 4) == 0) port_n = port_n ^ 4'($urandom);
      hold_in = 1'($urandom);
      if (($urandom % 64) == 0) begin arm_wr = 1; arm_data = 11'($urandom | $urandom); end
      if (($urandom % 64) == 0) begin mask_wr = 1; mask_data = 11'($urandom | $urandom); end
      cmd_ei = ($urandom % 6) == 0;
      cmd_di = ($urandom % 40) == 0;
      irq_ack = 1'($urandom);
      if (($urandom % 32) == 0) begin flag_clr = 1; flag_clr_mask = 11'($urandom); end
      cyc();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule